// File: doc/BRIEF.md
# Oversampled Serial Receiver with Per-Character Error Tags

This block turns an asynchronous serial input line into bytes. The line is first passed through a short synchronizer. It is then sampled on a 16x oversampling strobe that comes from outside the block. A falling edge on the idle-high line only starts a character once the line is still low half a bit later. After that, eight data bits (least significant first), an optional parity bit and a stop bit are each taken at their mid-bit sample.

Each finished character goes into a 16-entry first-word-fall-through queue. The entry carries three tag bits next to the byte: parity error, framing error and line break. A reader therefore always sees a character's status together with that character. A character that finishes while the queue is full is dropped, and a sticky overrun flag is raised. That flag is kept outside the queue and is cleared only by an explicit clear input.

Reception is gated by a global enable and a receive enable. Both must be high for a new start bit to be accepted. Dropping either one in the middle of a character does not cut that character short.

Top module: `uart_rx_tagged`

## Requirements
- R1: After synchronous reset the queue is empty (`empty_o`=1, `full_o`=0) and `ovr_o`=0.
- R2: A low level on `rx_i` that is no longer low at the eighth oversampling strobe after it was first seen (mid start bit) is discarded, and nothing is queued.
- R3: A valid frame is a start bit (0), then 8 data bits least significant bit first, then one parity bit when `par_en_i`=1, then a stop bit. Each bit lasts 16 strobes. The assembled byte appears on `rd_data_o`.
- R4: With parity enabled, the expected parity bit is the XOR of the data bits when `par_odd_i`=0, and its inverse when `par_odd_i`=1. A mismatch sets `rd_perr_o` for that entry. With parity disabled, `rd_perr_o` is 0.
- R5: A stop bit sampled low sets `rd_ferr_o` for that entry.
- R6: `rd_brk_o` is set for an entry when the data bits, the parity bit (if enabled) and the stop bit were all sampled low. Such an entry also has `rd_ferr_o`=1.
- R7: The queue holds 16 entries and returns them in arrival order. The head is visible while `empty_o`=0, and `rd_i` removes it. `rd_i` while empty has no effect.
- R8: A character that completes while the queue is full and `rd_i` is low is discarded, and it sets `ovr_o`. `ovr_o` stays set until `ovr_clr_i`. If a discard and `ovr_clr_i` happen in the same cycle, `ovr_o` remains set.
- R9: If a character completes in the same cycle that `rd_i` removes the head of a full queue, the character is stored, the queue stays full and `ovr_o` is not raised.
- R10: A start bit is accepted only while `en_i` and `rx_en_i` are both 1. A character whose start was accepted is completed and queued even if an enable falls during it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Global enable |
| rx_en_i | input | 1 | Receive enable |
| tick16_i | input | 1 | One-cycle strobe at 16x the bit rate |
| par_en_i | input | 1 | Parity bit present in the frame |
| par_odd_i | input | 1 | Odd parity when 1, even when 0 |
| rx_i | input | 1 | Serial line, idle high |
| rd_i | input | 1 | Remove the head entry |
| ovr_clr_i | input | 1 | Clear the overrun flag |
| rd_data_o | output | 8 | Head entry data byte |
| rd_perr_o | output | 1 | Head entry parity error tag |
| rd_ferr_o | output | 1 | Head entry framing error tag |
| rd_brk_o | output | 1 | Head entry break tag |
| empty_o | output | 1 | Queue empty |
| full_o | output | 1 | Queue holds 16 entries |
| ovr_o | output | 1 | Sticky overrun flag |

## Verification
Two events can land on the same clock edge: a character completing into a full queue, and a read or an overrun clear issued by the consumer. The bench controls each oversampling strobe itself, so it knows which strobe is the stop-bit sample. On that exact strobe it asserts `rd_i` in one run and `ovr_clr_i` in another. The read case is judged by `full_o` staying high, `ovr_o` staying low, and the new byte coming out last when the queue is drained. The clear case is judged by `ovr_o` still being set afterwards.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int DATA_W = 8;

    typedef struct packed {
        logic              brk;
        logic              ferr;
        logic              perr;
        logic [DATA_W-1:0] data;
    } rx_entry_t;

    typedef enum logic [2:0] {
        RX_IDLE  = 3'd0,
        RX_START = 3'd1,
        RX_DATA  = 3'd2,
        RX_PAR   = 3'd3,
        RX_STOP  = 3'd4
    } rx_state_e;

    // Parity bit a transmitter would send for this byte.
    function automatic logic par_expect(input logic [DATA_W-1:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction

    // Every sampled bit after the start bit was low.
    function automatic logic brk_detect(input logic [DATA_W-1:0] d, input logic pen,
                                        input logic pbit, input logic stopv);
        return (d == '0) && !stopv && (!pen || !pbit);
    endfunction

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], d_i};
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/rx_deframer.sv
module rx_deframer
    import uart_rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick_i,
    input  logic      go_i,
    input  logic      par_en_i,
    input  logic      par_odd_i,
    input  logic      rx_i,
    output logic      push_o,
    output rx_entry_t entry_o
);
    localparam int CW = $clog2(OSR);
    localparam int IW = $clog2(DATA_W);
    localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OSR - 1);
    localparam logic [IW-1:0] TOP  = IW'(DATA_W - 1);

    rx_state_e         state;
    logic [CW-1:0]     cnt;
    logic [IW-1:0]     idx;
    logic [DATA_W-1:0] shreg;
    logic              pbit;
    logic              pen_q;
    logic              odd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= RX_IDLE;
            cnt   <= '0;
            idx   <= '0;
            shreg <= '0;
            pbit  <= 1'b0;
            pen_q <= 1'b0;
            odd_q <= 1'b0;
        end else if (tick_i) begin
            unique case (state)
                RX_IDLE: begin
                    cnt <= '0;
                    if (!rx_i && go_i) begin
                        state <= RX_START;
                        pen_q <= par_en_i;
                        odd_q <= par_odd_i;
                    end
                end
                RX_START: begin
                    if (cnt == MID) begin
                        cnt <= '0;
                        idx <= '0;
                        state <= rx_i ? RX_IDLE : RX_DATA;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (cnt == LAST) begin
                        cnt   <= '0;
                        shreg <= {rx_i, shreg[DATA_W-1:1]};
                        if (idx == TOP) state <= pen_q ? RX_PAR : RX_STOP;
                        else            idx   <= idx + 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_PAR: begin
                    if (cnt == LAST) begin
                        cnt   <= '0;
                        pbit  <= rx_i;
                        state <= RX_STOP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (cnt == LAST) begin
                        cnt   <= '0;
                        state <= RX_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    // The entry is formed on the stop-bit sample and written on that same edge.
    assign push_o = tick_i && (state == RX_STOP) && (cnt == LAST);

    always_comb begin
        entry_o.data = shreg;
        entry_o.ferr = !rx_i;
        entry_o.perr = pen_q && (pbit != par_expect(shreg, odd_q));
        entry_o.brk  = brk_detect(shreg, pen_q, pbit, rx_i);
    end
endmodule

// File: rtl/rx_fifo.sv
module rx_fifo
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_i,
    input  rx_entry_t wdata_i,
    input  logic      rd_i,
    output rx_entry_t rdata_o,
    output logic      empty_o,
    output logic      full_o
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

    rx_entry_t     mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [AW:0]   count;
    logic          do_wr, do_rd;

    assign empty_o = (count == '0);
    assign full_o  = (count == FULL_CNT);
    assign do_rd   = rd_i && !empty_o;
    assign do_wr   = wr_i && (!full_o || do_rd);

    always_ff @(posedge clk) begin
        if (do_wr) mem[wptr] <= wdata_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_wr) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            if (do_rd) rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign rdata_o = mem[rptr];
endmodule

// File: rtl/uart_rx_tagged.sv
module uart_rx_tagged
    import uart_rx_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int DEPTH       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic              rx_en_i,
    input  logic              tick16_i,
    input  logic              par_en_i,
    input  logic              par_odd_i,
    input  logic              rx_i,
    input  logic              rd_i,
    input  logic              ovr_clr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_perr_o,
    output logic              rd_ferr_o,
    output logic              rd_brk_o,
    output logic              empty_o,
    output logic              full_o,
    output logic              ovr_o
);
    logic      rx_s;
    logic      push_w;
    logic      ovr_q;
    logic      ovr_set;
    rx_entry_t new_entry;
    rx_entry_t head;

    rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (rx_i),
        .q_o (rx_s)
    );

    rx_deframer #(.OSR(OSR)) u_deframe (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (tick16_i),
        .go_i      (en_i && rx_en_i),
        .par_en_i  (par_en_i),
        .par_odd_i (par_odd_i),
        .rx_i      (rx_s),
        .push_o    (push_w),
        .entry_o   (new_entry)
    );

    rx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (push_w),
        .wdata_i (new_entry),
        .rd_i    (rd_i),
        .rdata_o (head),
        .empty_o (empty_o),
        .full_o  (full_o)
    );

    // A read in the same cycle frees the slot, so only an unread full queue overruns.
    assign ovr_set = push_w && full_o && !rd_i;

    always_ff @(posedge clk) begin
        if (rst)            ovr_q <= 1'b0;
        else if (ovr_set)   ovr_q <= 1'b1;
        else if (ovr_clr_i) ovr_q <= 1'b0;
    end

    assign ovr_o     = ovr_q;
    assign rd_data_o = head.data;
    assign rd_perr_o = head.perr;
    assign rd_ferr_o = head.ferr;
    assign rd_brk_o  = head.brk;
endmodule

// File: rtl/uart_rx_tagged_chk.sv
module uart_rx_tagged_chk (
    input logic clk,
    input logic rst,
    input logic push_w,
    input logic rd_i,
    input logic ovr_clr_i,
    input logic empty_o,
    input logic full_o,
    input logic ovr_o
);
    a_r7_not_full_and_empty: assert property (@(posedge clk) disable iff (rst)
        !(full_o && empty_o));

    a_r7_empty_read_ignored: assert property (@(posedge clk) disable iff (rst)
        empty_o && !push_w |=> empty_o);

    a_r8_overrun_raises: assert property (@(posedge clk) disable iff (rst)
        push_w && full_o && !rd_i |=> ovr_o && full_o);

    a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
        ovr_o && !ovr_clr_i |=> ovr_o);

    a_r8_clear_works: assert property (@(posedge clk) disable iff (rst)
        ovr_clr_i && !(push_w && full_o && !rd_i) |=> !ovr_o);

    a_r9_read_frees_slot: assert property (@(posedge clk) disable iff (rst)
        push_w && full_o && rd_i |=> full_o && !$rose(ovr_o));
endmodule

bind uart_rx_tagged uart_rx_tagged_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .push_w    (push_w),
    .rd_i      (rd_i),
    .ovr_clr_i (ovr_clr_i),
    .empty_o   (empty_o),
    .full_o    (full_o),
    .ovr_o     (ovr_o)
);

// File: tb/uart_rx_tagged_test.sv
module uart_rx_tagged_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en_i = 1'b1, rx_en_i = 1'b1, tick16_i = 1'b0;
    logic par_en_i = 1'b0, par_odd_i = 1'b0, rx_i = 1'b1;
    logic rd_i = 1'b0, ovr_clr_i = 1'b0;
    logic [7:0] rd_data_o;
    logic rd_perr_o, rd_ferr_o, rd_brk_o, empty_o, full_o, ovr_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    logic [10:0] model[$];

    always #4 clk = ~clk;

    uart_rx_tagged uut (
        .clk(clk), .rst(rst), .en_i(en_i), .rx_en_i(rx_en_i), .tick16_i(tick16_i),
        .par_en_i(par_en_i), .par_odd_i(par_odd_i), .rx_i(rx_i), .rd_i(rd_i),
        .ovr_clr_i(ovr_clr_i), .rd_data_o(rd_data_o), .rd_perr_o(rd_perr_o),
        .rd_ferr_o(rd_ferr_o), .rd_brk_o(rd_brk_o), .empty_o(empty_o),
        .full_o(full_o), .ovr_o(ovr_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [10:0] expect_entry(input logic [7:0] d, input bit pe,
                                                 input bit odd, input bit flip, input bit stopv);
        logic pb = (^d) ^ odd ^ flip;
        logic brk = !stopv && (d == 8'h00) && (!pe || !pb);
        return {brk, !stopv, pe && flip, d};
    endfunction

    function automatic logic line_at(input int t, input logic [7:0] d, input bit pe,
                                     input logic pb, input bit stopv);
        int b = t / 16;
        if (b == 0) return 1'b0;
        if (b <= 8) return d[b-1];
        if (pe && b == 9) return pb;
        return stopv;
    endfunction

    // One oversampling strobe; the line has settled through the synchronizer first.
    task automatic strobe(input logic line, input bit rd, input bit clr);
        rx_i = line;
        repeat (3) @(negedge clk);
        tick16_i = 1'b1; rd_i = rd; ovr_clr_i = clr;
        @(negedge clk);
        tick16_i = 1'b0; rd_i = 1'b0; ovr_clr_i = 1'b0;
    endtask

    task automatic send(input logic [7:0] d, input bit pe, input bit odd, input bit flip,
                        input bit stopv, input bit rd_last, input bit clr_last, input int dis_at);
        int last = 8 + 16 * (9 + (pe ? 1 : 0));
        logic pb = (^d) ^ odd ^ flip;
        par_en_i = pe; par_odd_i = odd;
        for (int t = 0; t <= last; t++) begin
            if (t == dis_at) rx_en_i = 1'b0;
            strobe(line_at(t, d, pe, pb, stopv), (t == last) && rd_last, (t == last) && clr_last);
        end
        for (int k = 0; k < 2; k++) strobe(1'b1, 1'b0, 1'b0);
    endtask

    task automatic pop_check(input string req);
        logic [10:0] e;
        chk(!empty_o, {req, " empty"}, empty_o, 0);
        if (model.size() == 0) return;
        e = model.pop_front();
        chk({rd_brk_o, rd_ferr_o, rd_perr_o, rd_data_o} == e, req,
            {rd_brk_o, rd_ferr_o, rd_perr_o, rd_data_o}, e);
        rd_i = 1'b1;
        @(negedge clk);
        rd_i = 1'b0;
    endtask

    task automatic drain(input string req);
        while (model.size() > 0) pop_check(req);
        chk(empty_o == 1'b1, {req, " drained"}, empty_o, 1);
    endtask

    initial begin
        #(8ns * 190000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(empty_o && !full_o && !ovr_o, "R1 reset", {empty_o, full_o, ovr_o}, 3'b100);

        // R2 short low pulse is not a start bit
        for (int t = 0; t < 20; t++) strobe((t < 4) ? 1'b0 : 1'b1, 1'b0, 1'b0);
        chk(empty_o, "R2 glitch rejected", empty_o, 1);

        // R7 read on empty has no effect
        rd_i = 1'b1; @(negedge clk); rd_i = 1'b0;
        chk(empty_o && !full_o, "R7 read while empty", {empty_o, full_o}, 2'b10);

        // R3 plain byte, LSB first
        send(8'hA5, 0, 0, 0, 1, 0, 0, -1); model.push_back(expect_entry(8'hA5, 0, 0, 0, 1));
        drain("R3 byte no parity");
        // R4 even / odd parity, good and bad
        send(8'h3C, 1, 0, 0, 1, 0, 0, -1); model.push_back(expect_entry(8'h3C, 1, 0, 0, 1));
        send(8'h3C, 1, 1, 1, 1, 0, 0, -1); model.push_back(expect_entry(8'h3C, 1, 1, 1, 1));
        send(8'h81, 1, 0, 1, 1, 0, 0, -1); model.push_back(expect_entry(8'h81, 1, 0, 1, 1));
        drain("R4 parity");
        // R5 framing error
        send(8'h5A, 0, 0, 0, 0, 0, 0, -1); model.push_back(expect_entry(8'h5A, 0, 0, 0, 0));
        drain("R5 framing");
        // R6 break, with and without parity
        send(8'h00, 0, 0, 0, 0, 0, 0, -1); model.push_back(expect_entry(8'h00, 0, 0, 0, 0));
        send(8'h00, 1, 1, 1, 0, 0, 0, -1); model.push_back(expect_entry(8'h00, 1, 1, 1, 0));
        send(8'h00, 1, 0, 0, 1, 0, 0, -1); model.push_back(expect_entry(8'h00, 1, 0, 0, 1));
        drain("R6 break");

        // R10 disable mid-character completes; start while disabled ignored
        send(8'hC3, 0, 0, 0, 1, 0, 0, 20); model.push_back(expect_entry(8'hC3, 0, 0, 0, 1));
        drain("R10 complete after disable");
        send(8'h77, 0, 0, 0, 1, 0, 0, -1);
        chk(empty_o, "R10 receive disabled", empty_o, 1);
        rx_en_i = 1'b1; en_i = 1'b0;
        send(8'h77, 0, 0, 0, 1, 0, 0, -1);
        chk(empty_o, "R10 global disabled", empty_o, 1);
        en_i = 1'b1;

        // R7 / R8 fill, then overrun
        for (int i = 0; i < 16; i++) begin
            send(8'(i * 17 + 3), 0, 0, 0, 1, 0, 0, -1);
            model.push_back(expect_entry(8'(i * 17 + 3), 0, 0, 0, 1));
        end
        chk(full_o && !ovr_o, "R7 sixteen entries", {full_o, ovr_o}, 2'b10);
        send(8'hEE, 0, 0, 0, 1, 0, 0, -1);
        chk(ovr_o && full_o, "R8 overrun flagged", {ovr_o, full_o}, 2'b11);
        repeat (5) @(negedge clk);
        chk(ovr_o, "R8 overrun sticky", ovr_o, 1);
        send(8'hEF, 0, 0, 0, 1, 0, 1, -1);
        chk(ovr_o, "R8 set wins over clear", ovr_o, 1);
        ovr_clr_i = 1'b1; @(negedge clk); ovr_clr_i = 1'b0;
        chk(!ovr_o, "R8 cleared", ovr_o, 0);

        // R9 arrival and read in the same cycle while full
        chk({rd_brk_o, rd_ferr_o, rd_perr_o, rd_data_o} == model[0], "R9 head before",
            rd_data_o, model[0][7:0]);
        send(8'h5C, 0, 0, 0, 1, 1, 0, -1);
        void'(model.pop_front());
        model.push_back(expect_entry(8'h5C, 0, 0, 0, 1));
        chk(full_o && !ovr_o, "R9 no overrun", {full_o, ovr_o}, 2'b10);
        drain("R9 order after collision");

        // Random frames
        for (int n = 0; n < 24; n++) begin
            logic [7:0] d = 8'($urandom);
            bit pe = 1'($urandom), odd = 1'($urandom);
            bit flip = ($urandom % 4) == 0;
            bit stopv = ($urandom % 6) != 0;
            if (($urandom % 6) == 0) d = 8'h00;
            send(d, pe, odd, flip, stopv, 0, 0, -1);
            model.push_back(expect_entry(d, pe, odd, flip, stopv));
            if (model.size() > 10 || ($urandom % 3) == 0) drain("R3 R4 R5 R6 random");
        end
        drain("R7 random final");
        chk(!ovr_o, "R8 no spurious overrun", ovr_o, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule